// File: doc/BRIEF.md
# Double-Buffered I2C Master Receive Path

This block is the receive half of an I2C master once the address phase is over. A simple SCL generator supplies an abstract bit tick. Each tick moves the clock one half period: it either releases SCL high or pulls it low. Data bits are sampled from SDA, most significant bit first, at each rising half. After eight data bits comes a ninth clock. During that clock the master pulls SDA low to acknowledge, or leaves it released to signal a not-acknowledge.

The finished byte is copied into a holding register and a data-ready flag is raised. A byte can finish while the holding register still contains an unread byte. In that case it stays in the shift register, a both-full flag is raised, and SCL is held low so that the slave cannot send anything more. Reading the holding register then moves the waiting byte across and lets the bus run again.

A lookahead option changes when a cleared acknowledge enable takes effect, which makes the last byte of a short read get its not-acknowledge. A stop request ends the transfer with a STOP condition at the next byte boundary.

Top module: `i2c_rx_dbuf`

## Requirements
- R1: SDA is sampled on each tick that releases SCL, most significant bit first. When a byte's ninth clock ends and the holding register is empty (`flag_rxne`=0), the byte appears on `rx_byte` and `flag_rxne` goes to 1.
- R2: A `rd_strobe` pulse while `flag_rxne`=1 and `flag_btf`=0 clears `flag_rxne`, provided no byte completes in the same cycle.
- R3: If a byte's ninth clock ends while `flag_rxne`=1 and no read is given, `flag_btf` goes to 1 and `scl_drive_low` stays 1. Further ticks are ignored until a read.
- R4: A read while `flag_btf`=1 moves the waiting byte onto `rx_byte`. `flag_rxne` stays 1, `flag_btf` clears, and shifting resumes with the next tick.
- R5: With `pos_sel`=0, the value of `ack_en` at the tick that ends a byte's eighth bit decides the ninth clock. 1 drives `sda_drive_low`=1 (ACK) and 0 leaves it 0 (NACK).
- R6: With `pos_sel`=1, a byte is acknowledged according to the `ack_en` value captured at the previous byte's decision point, or at the clear-address pulse for the first byte. In a two-byte read where `ack_en` is cleared after the clear-address pulse, the first byte gets ACK and the second gets NACK.
- R7: A `stop_req` is held until the next byte boundary: the end of the current byte's ninth clock, or the release of a stall. At that point the block drives SDA low with SCL low instead of starting another byte. The next tick releases SCL, and the tick after that releases SDA.
- R8: `start_rx` sets `flag_addr` and holds SCL low. No bit is clocked until a `clr_addr` pulse clears `flag_addr`.
- R9: When the STOP completes, `flag_rxne` and `flag_btf` both become 0, while `rx_byte` keeps the last byte moved into it.
- R10: `sda_drive_low` changes only while SCL is driven low. The one exception is the release that forms the STOP condition.
- R11: After reset all flags are 0, both bus lines are released, and `rx_byte` is 0.
- R12: A read while `flag_rxne`=0 changes neither the flags nor `rx_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | Half-period tick from the SCL generator |
| sda_in | input | 1 | Sampled SDA level |
| start_rx | input | 1 | Receive phase begins (address matched) |
| clr_addr | input | 1 | Clear-address pulse, lets reception start |
| ack_en | input | 1 | Acknowledge enable |
| pos_sel | input | 1 | Apply acknowledge enable one byte later |
| stop_req | input | 1 | Request STOP at the next byte boundary |
| rd_strobe | input | 1 | Holding register read pulse |
| rx_byte | output | DATA_W | Holding register contents |
| flag_addr | output | 1 | Address-matched flag |
| flag_rxne | output | 1 | Holding register has an unread byte |
| flag_btf | output | 1 | Both registers full, SCL stretched |
| scl_drive_low | output | 1 | Pull SCL low (open drain) |
| sda_drive_low | output | 1 | Pull SDA low (open drain) |

## Verification
Three read lengths are run. A three-byte read with prompt acknowledge separates the empty-holding-register path from the stall path, and shows that ticks given during a stall are ignored. A two-byte read with the lookahead bit and an early read tells the delayed acknowledge apart from the immediate one, and checks the read-clears path. A one-byte read with a stop request queued before the byte finishes checks that the STOP follows the NACK directly, and that the flags flush while the data stays in place. Data patterns with distinct upper and lower halves (A5, 3C, 5A, 81, 7E, C3) would expose a bit-order or off-by-one shift error.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_BOUND,
    RX_SHIFT,
    RX_HOLD,
    RX_STOP_LO,
    RX_STOP_HI
  } rx_state_e;

  // Acknowledge choice: lookahead mode uses the value captured one byte earlier.
  function automatic logic ack_pick(input logic pos, input logic ack_now, input logic ack_prev);
    return pos ? ack_prev : ack_now;
  endfunction

endpackage

// File: rtl/i2crx_shift.sv
module i2crx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_byte,
  input  logic              rise_en,
  input  logic              fall_en,
  input  logic              sda_in,
  output logic [DATA_W-1:0] shreg,
  output logic              last_bit,
  output logic              ack_slot
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);
  localparam logic [CW-1:0] ACK_IDX  = CW'(DATA_W);

  logic [CW-1:0] cnt_q;

  function automatic logic [DATA_W-1:0] push_bit(input logic [DATA_W-1:0] cur, input logic b);
    return {cur[DATA_W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shreg <= '0;
    end else if (start_byte) begin
      cnt_q <= '0;
    end else begin
      if (rise_en && (cnt_q != ACK_IDX)) shreg <= push_bit(shreg, sda_in);
      if (fall_en && (cnt_q != ACK_IDX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_bit = (cnt_q == LAST_IDX);
  assign ack_slot = (cnt_q == ACK_IDX);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ACK_IDX);

endmodule

// File: rtl/i2crx_ackgen.sv
module i2crx_ackgen
  import i2crx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic decide,
  input  logic ack_en,
  input  logic pos_sel,
  output logic ack_eff
);
  logic ack_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               ack_prev_q <= 1'b0;
    else if (arm || decide)   ack_prev_q <= ack_en;
  end

  assign ack_eff = ack_pick(pos_sel, ack_en, ack_prev_q);

  // R6
  prev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> ack_prev_q == $past(ack_en));

endmodule

// File: rtl/i2crx_hold.sv
module i2crx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rd,
  input  logic              flush,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] dr,
  output logic              rxne,
  output logic              btf,
  output logic              accept,
  output logic              release_o
);
  assign accept    = load && (!rxne || rd);
  assign release_o = rd && btf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr   <= '0;
      rxne <= 1'b0;
      btf  <= 1'b0;
    end else if (flush) begin
      rxne <= 1'b0;
      btf  <= 1'b0;
    end else if (release_o) begin
      dr  <= src;
      btf <= 1'b0;
    end else if (load) begin
      if (accept) begin
        dr   <= src;
        rxne <= 1'b1;
      end else begin
        btf <= 1'b1;
      end
    end else if (rd) begin
      rxne <= 1'b0;
    end
  end

  // R3
  btf_rxne_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btf |-> rxne);

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && rxne && !btf && !load && !flush |=> !rxne);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && btf && !flush |=> rxne && !btf && dr == $past(src));

  // R12
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !rxne && !load |=> $stable(dr) && !rxne);

endmodule

// File: rtl/i2c_rx_dbuf.sv
module i2c_rx_dbuf
  import i2crx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              sda_in,
  input  logic              start_rx,
  input  logic              clr_addr,
  input  logic              ack_en,
  input  logic              pos_sel,
  input  logic              stop_req,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              flag_addr,
  output logic              flag_rxne,
  output logic              flag_btf,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  rx_state_e state_q;
  logic scl_hi_q, sda_lo_q, stop_pend_q;

  logic rise_w, fall_w, byte_done_w, start_byte_w, decide_w, arm_w, stop_rel_w;
  logic last_bit_w, ack_slot_w, ack_eff_w, accept_w, release_w;
  logic [DATA_W-1:0] shreg_w;

  assign rise_w       = (state_q == RX_SHIFT) && bit_tick && !scl_hi_q;
  assign fall_w       = (state_q == RX_SHIFT) && bit_tick &&  scl_hi_q;
  assign byte_done_w  = fall_w && ack_slot_w;
  assign decide_w     = fall_w && last_bit_w;
  assign start_byte_w = (state_q == RX_BOUND) && !stop_pend_q;
  assign arm_w        = (state_q == RX_ADDR) && clr_addr;
  assign stop_rel_w   = (state_q == RX_STOP_HI) && bit_tick;

  i2crx_shift #(.DATA_W(DATA_W)) shift_u (
    .clk(clk), .rst_n(rst_n), .start_byte(start_byte_w),
    .rise_en(rise_w), .fall_en(fall_w), .sda_in(sda_in),
    .shreg(shreg_w), .last_bit(last_bit_w), .ack_slot(ack_slot_w)
  );

  i2crx_ackgen ack_u (
    .clk(clk), .rst_n(rst_n), .arm(arm_w), .decide(decide_w),
    .ack_en(ack_en), .pos_sel(pos_sel), .ack_eff(ack_eff_w)
  );

  i2crx_hold #(.DATA_W(DATA_W)) hold_u (
    .clk(clk), .rst_n(rst_n), .load(byte_done_w), .rd(rd_strobe),
    .flush(stop_rel_w), .src(shreg_w), .dr(rx_byte),
    .rxne(flag_rxne), .btf(flag_btf), .accept(accept_w), .release_o(release_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      scl_hi_q    <= 1'b1;
      sda_lo_q    <= 1'b0;
      flag_addr   <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      if (stop_req && state_q != RX_IDLE) stop_pend_q <= 1'b1;
      unique case (state_q)
        RX_IDLE: if (start_rx) begin
          state_q   <= RX_ADDR;
          scl_hi_q  <= 1'b0;
          flag_addr <= 1'b1;
        end
        RX_ADDR: if (clr_addr) begin
          flag_addr <= 1'b0;
          state_q   <= RX_BOUND;
        end
        RX_BOUND: if (stop_pend_q) begin
          sda_lo_q <= 1'b1;
          state_q  <= RX_STOP_LO;
        end else begin
          state_q <= RX_SHIFT;
        end
        RX_SHIFT: if (bit_tick) begin
          if (!scl_hi_q) begin
            scl_hi_q <= 1'b1;
          end else begin
            scl_hi_q <= 1'b0;
            if (last_bit_w) sda_lo_q <= ack_eff_w;
            if (ack_slot_w) begin
              sda_lo_q <= 1'b0;
              state_q  <= accept_w ? RX_BOUND : RX_HOLD;
            end
          end
        end
        RX_HOLD: if (release_w) state_q <= RX_BOUND;
        RX_STOP_LO: if (bit_tick) begin
          scl_hi_q <= 1'b1;
          state_q  <= RX_STOP_HI;
        end
        RX_STOP_HI: if (bit_tick) begin
          sda_lo_q    <= 1'b0;
          state_q     <= RX_IDLE;
          stop_pend_q <= 1'b0;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign scl_drive_low = !scl_hi_q;
  assign sda_drive_low = sda_lo_q;

  // R3
  stall_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_btf |-> scl_drive_low);

  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hi_q && $past(scl_hi_q) && !$past(stop_rel_w) |-> $stable(sda_lo_q));

  // R8
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_addr |-> !rise_w && scl_drive_low);

  // R9
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rel_w |=> !flag_rxne && !flag_btf && $stable(rx_byte));

  // R7
  stop_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == RX_STOP_HI |-> !scl_drive_low && sda_drive_low);

endmodule

// File: tb/i2c_rx_dbuf_tb_top.sv
`timescale 1ns/1ps
module i2c_rx_dbuf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, sda_in = 1'b1, start_rx = 1'b0, clr_addr = 1'b0;
  logic ack_en = 1'b0, pos_sel = 1'b0, stop_req = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic flag_addr, flag_rxne, flag_btf, scl_drive_low, sda_drive_low;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_rx_dbuf #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sda_in(sda_in),
    .start_rx(start_rx), .clr_addr(clr_addr), .ack_en(ack_en), .pos_sel(pos_sel),
    .stop_req(stop_req), .rd_strobe(rd_strobe), .rx_byte(rx_byte),
    .flag_addr(flag_addr), .flag_rxne(flag_rxne), .flag_btf(flag_btf),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_rx = 1'b1;
    @(negedge clk) start_rx = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_addr = 1'b1;
    @(negedge clk) clr_addr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(output logic [7:0] got);
    got = rx_byte;
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  // Slave side: presents bits MSB first, returns the master's ninth-clock SDA.
  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_in = b[i];
      tick();
      tick();
      if (i == 0) check_eq("R10 SCL low when ack level set", scl_drive_low, 1);
    end
    sda_in = 1'b1;
    tick();
    check_eq("R5 SCL released in ninth clock", scl_drive_low, 0);
    acked = sda_drive_low;
    tick();
  endtask

  task automatic finish_stop(input logic [7:0] keep);
    check_eq("R7 STOP begins with SDA low", sda_drive_low, 1);
    check_eq("R7 STOP begins with SCL low", scl_drive_low, 1);
    tick();
    check_eq("R7 SCL released before SDA", scl_drive_low, 0);
    check_eq("R7 SDA still low", sda_drive_low, 1);
    tick();
    check_eq("R7 SDA released at STOP", sda_drive_low, 0);
    check_eq("R9 RXNE cleared by STOP", flag_rxne, 0);
    check_eq("R9 BTF cleared by STOP", flag_btf, 0);
    check_eq("R9 data kept after STOP", rx_byte, keep);
  endtask

  task automatic t_reset();
    check_eq("R11 rxne after reset", flag_rxne, 0);
    check_eq("R11 btf after reset", flag_btf, 0);
    check_eq("R11 addr after reset", flag_addr, 0);
    check_eq("R11 scl released", scl_drive_low, 0);
    check_eq("R11 sda released", sda_drive_low, 0);
    check_eq("R11 rx_byte", rx_byte, 0);
  endtask

  task automatic t_idle_read();
    logic [7:0] g;
    do_read(g);
    check_eq("R12 rxne unchanged", flag_rxne, 0);
    check_eq("R12 rx_byte unchanged", rx_byte, 0);
  endtask

  task automatic t_three_byte();
    logic a;
    logic [7:0] g;
    ack_en = 1'b1; pos_sel = 1'b0;
    pulse_start();
    check_eq("R8 addr flag set", flag_addr, 1);
    tick(); tick(); tick();
    check_eq("R8 SCL held before clear", scl_drive_low, 1);
    check_eq("R8 no byte before clear", flag_rxne, 0);
    pulse_clr();
    check_eq("R8 addr flag cleared", flag_addr, 0);
    send_byte(8'hA5, a);
    check_eq("R5 ACK with ack_en=1", a, 1);
    check_eq("R1 byte A5 in holding reg", rx_byte, 8'hA5);
    check_eq("R1 rxne set", flag_rxne, 1);
    check_eq("R1 btf clear", flag_btf, 0);
    send_byte(8'h3C, a);
    check_eq("R5 ACK second byte", a, 1);
    check_eq("R3 btf set", flag_btf, 1);
    check_eq("R3 holding reg kept", rx_byte, 8'hA5);
    tick(); tick(); tick(); tick();
    check_eq("R3 SCL stretched", scl_drive_low, 1);
    check_eq("R3 btf stays during ticks", flag_btf, 1);
    ack_en = 1'b0;
    do_read(g);
    check_eq("R4 read returns A5", g, 8'hA5);
    check_eq("R4 waiting byte moved", rx_byte, 8'h3C);
    check_eq("R4 rxne stays", flag_rxne, 1);
    check_eq("R4 btf cleared", flag_btf, 0);
    send_byte(8'h5A, a);
    check_eq("R5 NACK with ack_en=0", a, 0);
    check_eq("R3 btf on third byte", flag_btf, 1);
    pulse_stop();
    check_eq("R7 stop waits for stall", scl_drive_low, 1);
    do_read(g);
    check_eq("R4 read returns 3C", g, 8'h3C);
    check_eq("R4 last byte moved", rx_byte, 8'h5A);
    finish_stop(8'h5A);
  endtask

  task automatic t_two_byte_pos();
    logic a;
    logic [7:0] g;
    ack_en = 1'b1; pos_sel = 1'b1;
    pulse_start();
    pulse_clr();
    ack_en = 1'b0;
    send_byte(8'h81, a);
    check_eq("R6 first byte still ACKed", a, 1);
    check_eq("R1 byte 81", rx_byte, 8'h81);
    do_read(g);
    check_eq("R2 rxne cleared by read", flag_rxne, 0);
    pulse_stop();
    send_byte(8'h7E, a);
    check_eq("R6 second byte NACKed", a, 0);
    check_eq("R1 byte 7E into empty reg", rx_byte, 8'h7E);
    check_eq("R1 no btf with empty reg", flag_btf, 0);
    finish_stop(8'h7E);
  endtask

  task automatic t_single_byte();
    logic a;
    ack_en = 1'b0; pos_sel = 1'b0;
    pulse_start();
    pulse_clr();
    pulse_stop();
    send_byte(8'hC3, a);
    check_eq("R5 single byte NACK", a, 0);
    check_eq("R1 byte C3", rx_byte, 8'hC3);
    check_eq("R7 rxne before STOP completes", flag_rxne, 1);
    finish_stop(8'hC3);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_read();
    t_three_byte();
    t_two_byte_pos();
    t_single_byte();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      report();
    end
  end

endmodule